// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block translates a 32-bit I/O virtual address into a physical address. It walks a two-level translation table held in memory. A client presents a virtual address and the base of the first-level table. The walker then issues one or two word reads on a simple read port, one read in flight at a time. It decodes the descriptors it gets back. It returns either a physical address with a page-size code, or a fault with the faulting address and the table level at which the walk stopped.

Three mapping granules are supported. A first-level descriptor can map a 1 MiB section directly. It can also point at a second-level table of 256 entries, and each of those entries maps a 64 KiB large page or a 4 KiB small page. A large page is written into 16 adjacent second-level slots, so any of those slots yields the same mapping. Descriptors are not cached and permissions are not checked. Every request costs a full walk.

Top module: `pt_walker`

## Requirements
- R1: While and after reset, with no request given, busy_o, done_o, mem_req_o and fault_o are 0, and pa_o, size_o and fault_va_o are 0.
- R2: The first read of a walk goes to {base[31:14], va[31:20], 2'b00}; base bits [13:0] have no effect on it.
- R3: A first-level word whose bits[1:0] are 2'b10 ends the walk after one read with pa_o = {word[31:20], va[19:0]}, size_o = 2'b11 and fault_o = 0.
- R4: A first-level word whose bits[1:0] are 2'b01 causes a second read at {word[31:10], va[19:12], 2'b00}.
- R5: A first-level word whose bits[1:0] are 2'b00 or 2'b11 ends the walk after one read with fault_o = 1, fault_level_o = 0, fault_va_o = va, size_o = 2'b00 and pa_o = 0.
- R6: A second-level word with bit 1 set (bits[1:0] 2'b10 or 2'b11) gives pa_o = {word[31:12], va[11:0]} and size_o = 2'b01.
- R7: A second-level word with bits[1:0] = 2'b01 gives pa_o = {word[31:16], va[15:0]} and size_o = 2'b10. Any of the 16 replicated slots gives the same result.
- R8: A second-level word with bits[1:0] = 2'b00 gives fault_o = 1, fault_level_o = 1, fault_va_o = va, size_o = 2'b00 and pa_o = 0.
- R9: busy_o is high from the cycle after acceptance through the done cycle. done_o is a one-cycle pulse. With L cycles of read latency (rvalid sampled on the L-th edge after the request edge), done_o is high after edge k*(1+L) counted from the accepting edge, where k is the number of reads.
- R10: A request presented while busy_o is high is ignored. It starts no read, and it does not change the result of the walk in progress.
- R11: mem_req_o is a one-cycle pulse, and no new read is issued while one is outstanding.
- R12: pa_o, size_o, fault_o, fault_level_o and fault_va_o change only in the cycle where done_o is high, and hold between walks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Translate request, taken when busy_o is low |
| req_va_i | input | 32 | Virtual address to translate |
| req_base_i | input | 32 | First-level table base (bits [13:0] unused) |
| busy_o | output | 1 | Walk in progress |
| mem_req_o | output | 1 | One-cycle table read request |
| mem_addr_o | output | 32 | Byte address of the table word |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 32 | Table word read |
| done_o | output | 1 | One-cycle result strobe |
| fault_o | output | 1 | Walk ended in a translation fault |
| fault_level_o | output | 1 | Level that faulted: 0 first, 1 second |
| size_o | output | 2 | 00 fault, 01 4 KiB, 10 64 KiB, 11 1 MiB |
| pa_o | output | 32 | Translated physical address |
| fault_va_o | output | 32 | Faulting virtual address, 0 on success |

## Verification
The hardest case to create from the ports is a new request that arrives in the middle of a walk. It must be dropped, yet still leave the walk in progress unchanged. The bench raises req_valid_i with a different address one cycle after acceptance. It then checks that the result matches the first address and that no extra read follows. The second-level path is driven through every descriptor encoding and several read latencies, including two different replicated slots of one large page. The reference model compares busy, done and read addresses against its own cycle count on every clock of every walk.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;
  localparam int unsigned VA_W        = 32;
  localparam int unsigned SECT_SH     = 20;
  localparam int unsigned LARGE_SH    = 16;
  localparam int unsigned SMALL_SH    = 12;
  localparam int unsigned PTE_SH      = 2;
  localparam int unsigned L1_BASE_SH  = PTE_SH + VA_W - SECT_SH;
  localparam int unsigned L2_BASE_SH  = PTE_SH + SECT_SH - SMALL_SH;

  typedef enum logic [1:0] {
    SZ_NONE  = 2'b00,
    SZ_SMALL = 2'b01,
    SZ_LARGE = 2'b10,
    SZ_SECT  = 2'b11
  } pg_size_e;

  typedef enum logic [1:0] {
    L1_FAULT = 2'b00,
    L1_SECT  = 2'b01,
    L1_TABLE = 2'b10
  } l1_kind_e;
endpackage

// File: rtl/pt_l1_decode.sv
module pt_l1_decode
  import pt_walker_pkg::*;
(
  input  logic [VA_W-1:0] desc_i,
  input  logic [VA_W-1:0] va_i,
  output l1_kind_e        kind_o,
  output logic [VA_W-1:0] pa_o,
  output logic [VA_W-1:0] l2_addr_o
);
  always_comb begin
    unique case (desc_i[1:0])
      2'b10:   kind_o = L1_SECT;
      2'b01:   kind_o = L1_TABLE;
      default: kind_o = L1_FAULT;
    endcase
  end

  assign pa_o      = {desc_i[VA_W-1:SECT_SH], va_i[SECT_SH-1:0]};
  assign l2_addr_o = {desc_i[VA_W-1:L2_BASE_SH], va_i[SECT_SH-1:SMALL_SH], {PTE_SH{1'b0}}};
endmodule

// File: rtl/pt_l2_decode.sv
module pt_l2_decode
  import pt_walker_pkg::*;
(
  input  logic [VA_W-1:0] desc_i,
  input  logic [VA_W-1:0] va_i,
  output logic            fault_o,
  output pg_size_e        size_o,
  output logic [VA_W-1:0] pa_o
);
  always_comb begin
    fault_o = 1'b0;
    size_o  = SZ_NONE;
    pa_o    = '0;
    if (desc_i[1]) begin
      size_o = SZ_SMALL;
      pa_o   = {desc_i[VA_W-1:SMALL_SH], va_i[SMALL_SH-1:0]};
    end else if (desc_i[0]) begin
      size_o = SZ_LARGE;
      pa_o   = {desc_i[VA_W-1:LARGE_SH], va_i[LARGE_SH-1:0]};
    end else begin
      fault_o = 1'b1;
    end
  end
endmodule

// File: rtl/pt_walk_ctrl.sv
module pt_walk_ctrl
  import pt_walker_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            req_valid_i,
  input  logic [VA_W-1:0] req_va_i,
  input  logic [VA_W-1:0] req_base_i,
  output logic            busy_o,
  output logic            done_o,
  output logic            mem_req_o,
  output logic [VA_W-1:0] mem_addr_o,
  input  logic            mem_rvalid_i,
  output logic [VA_W-1:0] va_o,
  input  l1_kind_e        l1_kind_i,
  input  logic [VA_W-1:0] l1_pa_i,
  input  logic [VA_W-1:0] l1_l2_addr_i,
  input  logic            l2_fault_i,
  input  pg_size_e        l2_size_i,
  input  logic [VA_W-1:0] l2_pa_i,
  output logic            fault_o,
  output logic            fault_lvl_o,
  output pg_size_e        size_o,
  output logic [VA_W-1:0] pa_o,
  output logic [VA_W-1:0] fault_va_o
);
  typedef enum logic [2:0] {
    ST_IDLE, ST_L1_REQ, ST_L1_WAIT, ST_L2_REQ, ST_L2_WAIT, ST_DONE
  } walk_st_e;

  walk_st_e        state_q, state_d;
  logic [VA_W-1:0] va_q, base_q, l2_addr_q;
  logic            res_ld, res_fault, res_lvl;
  pg_size_e        res_size;
  logic [VA_W-1:0] res_pa;

  always_comb begin
    state_d   = state_q;
    res_ld    = 1'b0;
    res_fault = 1'b0;
    res_lvl   = 1'b0;
    res_size  = SZ_NONE;
    res_pa    = '0;
    unique case (state_q)
      ST_IDLE:   if (req_valid_i) state_d = ST_L1_REQ;
      ST_L1_REQ: state_d = ST_L1_WAIT;
      ST_L1_WAIT: if (mem_rvalid_i) begin
        if (l1_kind_i == L1_TABLE) begin
          state_d = ST_L2_REQ;
        end else begin
          state_d   = ST_DONE;
          res_ld    = 1'b1;
          res_fault = (l1_kind_i == L1_FAULT);
          res_size  = res_fault ? SZ_NONE : SZ_SECT;
          res_pa    = res_fault ? '0 : l1_pa_i;
        end
      end
      ST_L2_REQ: state_d = ST_L2_WAIT;
      ST_L2_WAIT: if (mem_rvalid_i) begin
        state_d   = ST_DONE;
        res_ld    = 1'b1;
        res_lvl   = 1'b1;
        res_fault = l2_fault_i;
        res_size  = l2_size_i;
        res_pa    = l2_pa_i;
      end
      ST_DONE:   state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      va_q        <= '0;
      base_q      <= '0;
      l2_addr_q   <= '0;
      fault_o     <= 1'b0;
      fault_lvl_o <= 1'b0;
      size_o      <= SZ_NONE;
      pa_o        <= '0;
      fault_va_o  <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE && req_valid_i) begin
        va_q   <= req_va_i;
        base_q <= req_base_i;
      end
      if (state_q == ST_L1_WAIT && mem_rvalid_i && l1_kind_i == L1_TABLE)
        l2_addr_q <= l1_l2_addr_i;
      if (res_ld) begin
        fault_o     <= res_fault;
        fault_lvl_o <= res_fault & res_lvl;
        size_o      <= res_size;
        pa_o        <= res_pa;
        fault_va_o  <= res_fault ? va_q : '0;
      end
    end
  end

  assign busy_o     = (state_q != ST_IDLE);
  assign done_o     = (state_q == ST_DONE);
  assign mem_req_o  = (state_q == ST_L1_REQ) || (state_q == ST_L2_REQ);
  assign mem_addr_o = (state_q == ST_L2_REQ) ? l2_addr_q
                    : {base_q[VA_W-1:L1_BASE_SH], va_q[VA_W-1:SECT_SH], {PTE_SH{1'b0}}};
  assign va_o       = va_q;
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pt_walker_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_valid_i,
  input  logic [31:0] req_va_i,
  input  logic [31:0] req_base_i,
  output logic        busy_o,
  output logic        mem_req_o,
  output logic [31:0] mem_addr_o,
  input  logic        mem_rvalid_i,
  input  logic [31:0] mem_rdata_i,
  output logic        done_o,
  output logic        fault_o,
  output logic        fault_level_o,
  output logic [1:0]  size_o,
  output logic [31:0] pa_o,
  output logic [31:0] fault_va_o
);
  logic [VA_W-1:0] va_w, l1_pa_w, l1_l2_addr_w, l2_pa_w;
  l1_kind_e        l1_kind_w;
  logic            l2_fault_w;
  pg_size_e        l2_size_w, size_w;

  pt_l1_decode u_l1 (
    .desc_i    (mem_rdata_i),
    .va_i      (va_w),
    .kind_o    (l1_kind_w),
    .pa_o      (l1_pa_w),
    .l2_addr_o (l1_l2_addr_w)
  );

  pt_l2_decode u_l2 (
    .desc_i  (mem_rdata_i),
    .va_i    (va_w),
    .fault_o (l2_fault_w),
    .size_o  (l2_size_w),
    .pa_o    (l2_pa_w)
  );

  pt_walk_ctrl u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_valid_i  (req_valid_i),
    .req_va_i     (req_va_i),
    .req_base_i   (req_base_i),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .mem_req_o    (mem_req_o),
    .mem_addr_o   (mem_addr_o),
    .mem_rvalid_i (mem_rvalid_i),
    .va_o         (va_w),
    .l1_kind_i    (l1_kind_w),
    .l1_pa_i      (l1_pa_w),
    .l1_l2_addr_i (l1_l2_addr_w),
    .l2_fault_i   (l2_fault_w),
    .l2_size_i    (l2_size_w),
    .l2_pa_i      (l2_pa_w),
    .fault_o      (fault_o),
    .fault_lvl_o  (fault_level_o),
    .size_o       (size_w),
    .pa_o         (pa_o),
    .fault_va_o   (fault_va_o)
  );

  assign size_o = size_w;
endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        req_valid_i,
  input logic [31:0] req_va_i,
  input logic [31:0] req_base_i,
  input logic        busy_o,
  input logic        mem_req_o,
  input logic [31:0] mem_addr_o,
  input logic        mem_rvalid_i,
  input logic        done_o,
  input logic        fault_o,
  input logic        fault_level_o,
  input logic [1:0]  size_o,
  input logic [31:0] pa_o,
  input logic [31:0] fault_va_o
);
  logic        outst_q, first_q;
  logic [31:0] va_cap_q, base_cap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      outst_q    <= 1'b0;
      first_q    <= 1'b0;
      va_cap_q   <= '0;
      base_cap_q <= '0;
    end else begin
      if (mem_req_o)         outst_q <= 1'b1;
      else if (mem_rvalid_i) outst_q <= 1'b0;
      if (req_valid_i && !busy_o) begin
        va_cap_q   <= req_va_i;
        base_cap_q <= req_base_i;
        first_q    <= 1'b1;
      end else if (mem_req_o) begin
        first_q <= 1'b0;
      end
    end
  end

  assert_done_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_busy_at_done_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> busy_o);
  assert_req_pulse_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |=> !mem_req_o);
  assert_one_outstanding_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> !outst_q);
  assert_l1_addr_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && first_q) |-> mem_addr_o == {base_cap_q[31:14], va_cap_q[31:20], 2'b00});
  assert_fault_info_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && fault_o) |-> (size_o == 2'b00 && pa_o == 32'h0 && fault_va_o == va_cap_q));
  assert_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> ($stable(pa_o) && $stable(size_o) && $stable(fault_o)
                 && $stable(fault_level_o) && $stable(fault_va_o)));
endmodule

bind pt_walker pt_walker_chk u_chk (.*);

// File: tb/tb_pt_walker.sv
module tb_pt_walker;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_va = '0, req_base = '0;
  logic        busy, mem_req, mem_rvalid, done, fault, fault_lvl;
  logic [31:0] mem_addr, mem_rdata, pa, fault_va;
  logic [1:0]  size;

  int checks = 0, errors = 0, lat_g = 1;
  bit finished = 0;

  logic [31:0] mem_a [logic [31:0]];

  always #(CLK_PERIOD/2) clk = ~clk;

  pt_walker dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_va_i(req_va),
    .req_base_i(req_base), .busy_o(busy), .mem_req_o(mem_req), .mem_addr_o(mem_addr),
    .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata), .done_o(done), .fault_o(fault),
    .fault_level_o(fault_lvl), .size_o(size), .pa_o(pa), .fault_va_o(fault_va)
  );

  function automatic logic [31:0] rd(input logic [31:0] a);
    return mem_a.exists(a) ? mem_a[a] : 32'h0;
  endfunction

  // memory: answers lat_g negedges after it sees a request
  bit          pend = 0;
  int          cnt = 0;
  logic [31:0] paddr = '0;
  initial begin mem_rvalid = 1'b0; mem_rdata = '0; end
  always @(negedge clk) begin
    mem_rvalid = 1'b0;
    if (pend) begin
      if (cnt == 1) begin
        mem_rvalid = 1'b1;
        mem_rdata  = rd(paddr);
        pend = 0;
      end else cnt--;
    end
    if (mem_req) begin
      pend = 1; cnt = lat_g; paddr = mem_addr;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference of one walk
  task automatic ref_walk(input logic [31:0] va, input logic [31:0] base,
                          output int lv, output logic [31:0] a1, output logic [31:0] a2,
                          output logic f, output logic fl, output logic [1:0] sz,
                          output logic [31:0] epa, output logic [31:0] efva);
    logic [31:0] d1, d2;
    a1 = (base & 32'hFFFF_C000) | ((va >> 20) << 2);
    d1 = rd(a1);
    a2 = '0; f = 0; fl = 0; sz = 2'b00; epa = '0; efva = '0; lv = 1;
    if (d1[1:0] == 2'b10) begin
      sz = 2'b11; epa = (d1 & 32'hFFF0_0000) | (va & 32'h000F_FFFF);
    end else if (d1[1:0] == 2'b01) begin
      lv = 2;
      a2 = (d1 & 32'hFFFF_FC00) | (((va >> 12) & 32'hFF) << 2);
      d2 = rd(a2);
      if (d2[1]) begin
        sz = 2'b01; epa = (d2 & 32'hFFFF_F000) | (va & 32'hFFF);
      end else if (d2[0]) begin
        sz = 2'b10; epa = (d2 & 32'hFFFF_0000) | (va & 32'hFFFF);
      end else begin
        f = 1; fl = 1; efva = va;
      end
    end else begin
      f = 1; efva = va;
    end
  endtask

  task automatic xact(input logic [31:0] va, input logic [31:0] base, input int lat,
                      input bit inject, input string tag);
    int lv, n;
    logic [31:0] a1, a2, epa, efva;
    logic f, fl;
    logic [1:0] sz;
    ref_walk(va, base, lv, a1, a2, f, fl, sz, epa, efva);
    lat_g = lat;
    n = lv * (1 + lat);
    @(negedge clk);
    req_valid = 1'b1; req_va = va; req_base = base;
    @(negedge clk);
    req_valid = 1'b0;
    for (int j = 0; j <= n + 1; j++) begin
      if (j > 0) @(negedge clk);
      if (inject && j == 1) begin
        req_valid = 1'b1; req_va = va ^ 32'hFFF0_0000; req_base = base ^ 32'h0100_0000;
      end
      if (inject && j == 2) req_valid = 1'b0;
      // R9 busy/done timing compared every clock
      chk(busy == (j <= n), {tag, " R9 busy"}, 32'(busy), 32'(j <= n));
      chk(done == (j == n), {tag, " R9 done"}, 32'(done), 32'(j == n));
      // R2/R4/R11 read issue cycles and addresses
      if (j == 0) begin
        chk(mem_req == 1'b1, {tag, " R2 l1 req"}, 32'(mem_req), 32'd1);
        chk(mem_addr == a1, {tag, " R2 l1 addr"}, mem_addr, a1);
      end else if (lv == 2 && j == 1 + lat) begin
        chk(mem_req == 1'b1, {tag, " R4 l2 req"}, 32'(mem_req), 32'd1);
        chk(mem_addr == a2, {tag, " R4 l2 addr"}, mem_addr, a2);
      end else begin
        chk(mem_req == 1'b0, {tag, " R10 R11 no req"}, 32'(mem_req), 32'd0);
      end
      if (j == n) begin
        chk(fault == f, {tag, " R5 R8 fault"}, 32'(fault), 32'(f));
        chk(fault_lvl == fl, {tag, " R5 R8 level"}, 32'(fault_lvl), 32'(fl));
        chk(size == sz, {tag, " R3 R6 R7 size"}, 32'(size), 32'(sz));
        chk(pa == epa, {tag, " R3 R6 R7 pa"}, pa, epa);
        chk(fault_va == efva, {tag, " R5 R8 fault va"}, fault_va, efva);
      end
      if (j == n + 1) begin
        chk(pa == epa, {tag, " R12 hold"}, pa, epa);
      end
    end
  endtask

  localparam logic [31:0] BASE = 32'h0004_0000;
  localparam logic [31:0] L2T  = 32'h0008_0400;

  initial begin
    mem_a[BASE + (32'h123 << 2)] = 32'hABC0_0002;
    mem_a[BASE + (32'h001 << 2)] = L2T | 32'h1;
    mem_a[L2T + (32'h02 << 2)]   = 32'h5555_6002;
    mem_a[L2T + (32'h03 << 2)]   = 32'h7777_7003;
    for (int i = 16; i < 32; i++) mem_a[L2T + 32'(i << 2)] = 32'h9876_0001;
    mem_a[BASE + (32'h300 << 2)] = 32'hFFFF_FFFF;

    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!busy && !done && !mem_req && !fault, "R1 ctrl", {busy, done, mem_req, fault}, 32'h0);
    chk(pa == 0 && size == 0 && fault_va == 0, "R1 data", pa, 32'h0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!busy && !mem_req && !done, "R1 after release", {busy, mem_req, done}, 32'h0);

    xact(32'h1234_5678, BASE, 1, 0, "sect");                 // R3
    xact(32'h1234_5678, BASE | 32'h3ABC, 2, 0, "base_lo");   // R2
    xact(32'h0010_2345, BASE, 1, 0, "small10");              // R4 R6
    xact(32'h0010_3FFF, BASE, 3, 0, "small11");              // R6
    xact(32'h0011_4ABC, BASE, 2, 0, "large_a");              // R7
    xact(32'h0011_FFFF, BASE, 1, 0, "large_b");              // R7 replica
    xact(32'h0010_5000, BASE, 4, 0, "l2fault");              // R8
    xact(32'h2000_0000, BASE, 1, 0, "l1f00");                // R5
    xact(32'h3000_0010, BASE, 5, 0, "l1f11");                // R5
    xact(32'h0010_2345, BASE, 2, 1, "inject");               // R10
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk(!busy && !mem_req, "R10 no restart", {busy, mem_req}, 32'h0);
    end
    xact(32'h1234_5678, BASE, 1, 0, "sect2");                // R12 / R3 after fault

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog R9 act=%h exp=%h", 32'h0, 32'h1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule